// File: doc/BRIEF.md
# Heterogeneous Coherence Snoop Wrapper

This block sits between one processor's snoop port and the shared system bus. Caches on the bus may run different coherence protocols, some with an Exclusive state and some with a Shared state. Those caches can only stay consistent if every one of them is held to the states they all have. The wrapper does this without changing the caches. It rewrites the type of each transaction that another master puts on the bus before the local cache sees it as a snoop. It also overrides the shared indication that the local cache samples when it fills a line from memory.

A static parameter picks the pairing. When a three-state cache with no Shared state is combined with a four-state cache, the wrapper turns each snooped read into a snooped read-for-ownership. The local cache then drops its line instead of keeping a Shared copy. It also holds shared low on local fills, so that a clean fill lands in Exclusive. When a three-state cache with no Exclusive state is combined with a four-state cache, the wrapper forces shared high on every local read fill. The four-state cache then never reaches Exclusive, and a later store from it has to appear on the bus, where it invalidates the other copy. A third setting lets everything through unchanged.

The wrapper also protects Modified data. If the local cache reports that a snoop hit a Modified line, the wrapper retries the bus until the local cache has written that line back.

Top module: `coh_wrap`

## Requirements
- R1: While reset is held, and in the first cycle after it, `snp_valid` and `bus_retry` are 0.
- R2: A bus transaction whose type is not idle (`bus_valid`=1, `bus_type`≠00) shows up on `snp_valid`/`snp_addr` exactly one clock later. In a cycle with `bus_valid`=0, or with type 00, `snp_valid` is 0 in the next cycle.
- R3: In MEI_MESI mode a snooped read (type 01) is presented as read-for-ownership (type 10). Types 10 and 11 are presented unchanged.
- R4: In MSI_MESI and PASSTHROUGH modes the presented snoop type equals the bus type.
- R5: In MSI_MESI mode `lcl_shared` is 1 whenever the local processor issues a read (`lcl_req_valid`=1, `lcl_req_type`=01).
- R6: In MEI_MESI mode `lcl_shared` is 0 whenever the local processor issues a read (type 01).
- R7: In PASSTHROUGH mode, and in every mode whenever no local read (type 01) is issued, `lcl_shared` equals `bus_shared_in`.
- R8: `bus_retry` is 1 in the cycle where `snp_valid`=1 and `lcl_hitm`=1. It then stays 1 up to and including the cycle in which the local processor issues a write-back (type 11) to the snooped address, and it is 0 in the next cycle.
- R9: While a retry is pending, a local write-back to any other address, or a local request of any other type to the same address, leaves `bus_retry` at 1.
- R10: If a new Modified hit and the clearing write-back for the previous one fall in the same cycle, the new hit wins. `bus_retry` stays 1 until a write-back to the new address is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Address phase of a transaction from another master |
| bus_type | input | 2 | Bus transaction type: 00 idle, 01 read, 10 read-for-ownership/write, 11 write-back |
| bus_addr | input | AW | Bus transaction line address |
| bus_shared_in | input | 1 | Shared indication driven by the other caches |
| bus_retry | output | 1 | Retry request toward the bus |
| snp_valid | output | 1 | Snoop presented to the local cache |
| snp_type | output | 2 | Rewritten snoop type (same encoding as `bus_type`) |
| snp_addr | output | AW | Snoop line address |
| lcl_hitm | input | 1 | Local cache reports that the current snoop hit a Modified line |
| lcl_shared | output | 1 | Shared indication sampled by the local cache on fills |
| lcl_req_valid | input | 1 | Local processor bus request |
| lcl_req_type | input | 2 | Local request type (same encoding) |
| lcl_req_addr | input | AW | Local request line address |

## Verification
Two pairs of functions can land in one cycle. The first pair is a new Modified hit that arms retry and the write-back that releases the previous retry. The bench provokes this on purpose by issuing the clearing write-back in the same cycle that `lcl_hitm` answers a second snoop. It then checks that retry stays high and is released only by a write-back to the second address. The second pair is a local read fill whose shared override must win over `bus_shared_in`, while a snoop of a different type is presented in that same cycle. Three instances, one per mode, share the same stimulus. A behavioural model that steps every clock predicts each output, and directed sequences are followed by a long random run with addresses drawn from a small set, so that write-backs often match.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    MODE_MEI_MESI = 2'd0,
    MODE_MSI_MESI = 2'd1,
    MODE_PASS     = 2'd2
  } coh_mode_e;

  localparam logic [1:0] BT_IDLE  = 2'b00;
  localparam logic [1:0] BT_READ  = 2'b01;
  localparam logic [1:0] BT_RWITM = 2'b10;
  localparam logic [1:0] BT_WB    = 2'b11;

  // Snoop type seen by the local cache for a given bus type.
  function automatic logic [1:0] xlate_type(coh_mode_e m, logic [1:0] t);
    logic [1:0] r;
    r = t;
    if (m == MODE_MEI_MESI && t == BT_READ) r = BT_RWITM;
    return r;
  endfunction

  // Shared level sampled by the local cache.
  function automatic logic shared_view(coh_mode_e m, logic is_fill, logic bus_sh);
    logic r;
    r = bus_sh;
    if (is_fill) begin
      case (m)
        MODE_MEI_MESI: r = 1'b0;
        MODE_MSI_MESI: r = 1'b1;
        default:       r = bus_sh;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/coh_snoop_xlate.sv
module coh_snoop_xlate
  import coh_pkg::*;
#(
  parameter coh_mode_e MODE = MODE_MEI_MESI,
  parameter int        AW   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic [1:0]    bus_type,
  input  logic [AW-1:0] bus_addr,
  output logic          snp_valid,
  output logic [1:0]    snp_type,
  output logic [AW-1:0] snp_addr
);

  logic capture;
  assign capture = bus_valid && (bus_type != BT_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snp_valid <= 1'b0;
      snp_type  <= BT_IDLE;
      snp_addr  <= '0;
    end else begin
      snp_valid <= capture;
      if (capture) begin
        snp_type <= xlate_type(MODE, bus_type);
        snp_addr <= bus_addr;
      end
    end
  end

  AST_SNP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (snp_valid && snp_addr == $past(bus_addr))); // R2
  AST_SNP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> !snp_valid); // R2

  generate
    if (MODE == MODE_MEI_MESI) begin : g_conv
      AST_NO_READ_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> (snp_type != BT_READ)); // R3
    end else begin : g_keep
      AST_TYPE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (snp_type == $past(bus_type))); // R4
    end
  endgenerate

endmodule

// File: rtl/coh_shared_ctl.sv
module coh_shared_ctl
  import coh_pkg::*;
#(
  parameter coh_mode_e MODE = MODE_MEI_MESI
) (
  input  logic       lcl_req_valid,
  input  logic [1:0] lcl_req_type,
  input  logic       bus_shared_in,
  output logic       read_fill,
  output logic       lcl_shared
);

  assign read_fill  = lcl_req_valid && (lcl_req_type == BT_READ);
  assign lcl_shared = shared_view(MODE, read_fill, bus_shared_in);

endmodule

// File: rtl/coh_retry_trk.sv
module coh_retry_trk
  import coh_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          snp_valid,
  input  logic [AW-1:0] snp_addr,
  input  logic          lcl_hitm,
  input  logic          lcl_req_valid,
  input  logic [1:0]    lcl_req_type,
  input  logic [AW-1:0] lcl_req_addr,
  output logic          pend_set,
  output logic          wb_fire,
  output logic          bus_retry
);

  logic          pend_q;
  logic [AW-1:0] pend_addr_q;
  logic          wb_other;

  assign pend_set = snp_valid && lcl_hitm;
  assign wb_fire  = pend_q && lcl_req_valid && (lcl_req_type == BT_WB)
                    && (lcl_req_addr == pend_addr_q);
  assign wb_other = pend_q && lcl_req_valid && !wb_fire;
  assign bus_retry = pend_q || pend_set;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
    end else if (pend_set) begin
      pend_q      <= 1'b1;
      pend_addr_q <= snp_addr;
    end else if (wb_fire) begin
      pend_q      <= 1'b0;
    end
  end

  AST_RETRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_retry && !wb_fire) |=> bus_retry); // R8
  AST_RETRY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_retry) |-> $past(wb_fire)); // R8
  AST_WB_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    wb_other |=> bus_retry); // R9
  AST_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_set && wb_fire) |=> bus_retry); // R10

endmodule

// File: rtl/coh_wrap.sv
module coh_wrap
  import coh_pkg::*;
#(
  parameter coh_mode_e MODE = MODE_MEI_MESI,
  parameter int        AW   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic [1:0]    bus_type,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_shared_in,
  output logic          bus_retry,
  output logic          snp_valid,
  output logic [1:0]    snp_type,
  output logic [AW-1:0] snp_addr,
  input  logic          lcl_hitm,
  output logic          lcl_shared,
  input  logic          lcl_req_valid,
  input  logic [1:0]    lcl_req_type,
  input  logic [AW-1:0] lcl_req_addr
);

  logic read_fill;
  logic pend_set;
  logic wb_fire;

  coh_snoop_xlate #(.MODE(MODE), .AW(AW)) u_xlate (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_type  (bus_type),
    .bus_addr  (bus_addr),
    .snp_valid (snp_valid),
    .snp_type  (snp_type),
    .snp_addr  (snp_addr)
  );

  coh_shared_ctl #(.MODE(MODE)) u_shared (
    .lcl_req_valid (lcl_req_valid),
    .lcl_req_type  (lcl_req_type),
    .bus_shared_in (bus_shared_in),
    .read_fill     (read_fill),
    .lcl_shared    (lcl_shared)
  );

  coh_retry_trk #(.AW(AW)) u_retry (
    .clk           (clk),
    .rst_n         (rst_n),
    .snp_valid     (snp_valid),
    .snp_addr      (snp_addr),
    .lcl_hitm      (lcl_hitm),
    .lcl_req_valid (lcl_req_valid),
    .lcl_req_type  (lcl_req_type),
    .lcl_req_addr  (lcl_req_addr),
    .pend_set      (pend_set),
    .wb_fire       (wb_fire),
    .bus_retry     (bus_retry)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!snp_valid && !bus_retry)); // R1
  AST_HITM_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    pend_set |-> bus_retry); // R8

  generate
    if (MODE == MODE_MSI_MESI) begin : g_msi
      AST_SHARED_FORCED_HI: assert property (@(posedge clk) disable iff (!rst_n)
        read_fill |-> lcl_shared); // R5
    end else if (MODE == MODE_MEI_MESI) begin : g_mei
      AST_SHARED_FORCED_LO: assert property (@(posedge clk) disable iff (!rst_n)
        read_fill |-> !lcl_shared); // R6
    end
  endgenerate

  AST_SHARED_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!read_fill || MODE == MODE_PASS) |-> (lcl_shared == bus_shared_in)); // R7

endmodule

// File: tb/coh_wrap_bench.sv
`timescale 1ns/1ps
module coh_wrap_bench;
  import coh_pkg::*;

  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_valid, bus_shared_in, lcl_hitm, lcl_req_valid;
  logic [1:0]    bus_type, lcl_req_type;
  logic [AW-1:0] bus_addr, lcl_req_addr;

  logic          retry   [3];
  logic          sv      [3];
  logic [1:0]    st      [3];
  logic [AW-1:0] sa      [3];
  logic          shared  [3];

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // model state
  bit       m_sv;
  int       m_st, m_sa;
  bit       m_pend;
  int       m_pa;

  always #2 clk = ~clk;

  coh_wrap #(.MODE(MODE_MEI_MESI), .AW(AW)) u_coh_wrap (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_type(bus_type),
    .bus_addr(bus_addr), .bus_shared_in(bus_shared_in), .bus_retry(retry[0]),
    .snp_valid(sv[0]), .snp_type(st[0]), .snp_addr(sa[0]), .lcl_hitm(lcl_hitm),
    .lcl_shared(shared[0]), .lcl_req_valid(lcl_req_valid),
    .lcl_req_type(lcl_req_type), .lcl_req_addr(lcl_req_addr));

  coh_wrap #(.MODE(MODE_MSI_MESI), .AW(AW)) u_coh_wrap_msi (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_type(bus_type),
    .bus_addr(bus_addr), .bus_shared_in(bus_shared_in), .bus_retry(retry[1]),
    .snp_valid(sv[1]), .snp_type(st[1]), .snp_addr(sa[1]), .lcl_hitm(lcl_hitm),
    .lcl_shared(shared[1]), .lcl_req_valid(lcl_req_valid),
    .lcl_req_type(lcl_req_type), .lcl_req_addr(lcl_req_addr));

  coh_wrap #(.MODE(MODE_PASS), .AW(AW)) u_coh_wrap_pass (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_type(bus_type),
    .bus_addr(bus_addr), .bus_shared_in(bus_shared_in), .bus_retry(retry[2]),
    .snp_valid(sv[2]), .snp_type(st[2]), .snp_addr(sa[2]), .lcl_hitm(lcl_hitm),
    .lcl_shared(shared[2]), .lcl_req_valid(lcl_req_valid),
    .lcl_req_type(lcl_req_type), .lcl_req_addr(lcl_req_addr));

  task automatic chk(string tag, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s at %0t: actual %0d expected %0d", tag, what, $time, act, exp);
    end
  endtask

  // Expected type: mode 0 promotes a read (1) to ownership (2).
  function automatic int model_type(int mode, int t);
    if (mode == 0 && t == 1) return 2;
    return t;
  endfunction

  function automatic int model_shared(int mode, bit rd, bit bsh);
    if (!rd) return bsh;
    if (mode == 0) return 0;
    if (mode == 1) return 1;
    return bsh;
  endfunction

  task automatic compare_all(string rtag);
    bit rd;
    rd = lcl_req_valid && lcl_req_type == 2'b01;
    for (int i = 0; i < 3; i++) begin
      string stag;
      chk("R2", "snp_valid", sv[i], m_sv);
      if (m_sv) begin
        chk("R2", "snp_addr", sa[i], m_sa);
        chk(i == 0 ? "R3" : "R4", "snp_type", st[i], model_type(i, m_st));
      end
      stag = !rd ? "R7" : (i == 0 ? "R6" : (i == 1 ? "R5" : "R7"));
      chk(stag, "lcl_shared", shared[i], model_shared(i, rd, bus_shared_in));
      chk(rtag, "bus_retry", retry[i], (m_pend || (m_sv && lcl_hitm)) ? 1 : 0);
    end
  endtask

  // One cycle: drive at negedge, compare, then advance model at posedge.
  task automatic step(bit bv, int bt, int ba, bit bsh, bit hm,
                      bit rv, int rt, int ra, string rtag = "R8");
    bit set, fire;
    bus_valid = bv; bus_type = 2'(bt); bus_addr = AW'(ba);
    bus_shared_in = bsh; lcl_hitm = hm;
    lcl_req_valid = rv; lcl_req_type = 2'(rt); lcl_req_addr = AW'(ra);
    #1;
    compare_all(rtag);
    @(posedge clk);
    set  = m_sv && hm;
    fire = m_pend && rv && rt == 3 && ra == m_pa;
    if (set) begin m_pend = 1; m_pa = m_sa; end
    else if (fire) m_pend = 0;
    if (bv && bt != 0) begin m_sv = 1; m_st = bt; m_sa = ba; end
    else m_sv = 0;
    @(negedge clk);
  endtask

  task automatic idle(string rtag = "R8");
    step(0, 0, 0, 0, 0, 0, 0, 0, rtag);
  endtask

  initial begin
    rst_n = 1'b0;
    bus_valid = 0; bus_type = 0; bus_addr = 0; bus_shared_in = 0;
    lcl_hitm = 0; lcl_req_valid = 0; lcl_req_type = 0; lcl_req_addr = 0;
    m_sv = 0; m_st = 0; m_sa = 0; m_pend = 0; m_pa = 0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      chk("R1", "reset snp_valid", sv[i], 0);
      chk("R1", "reset bus_retry", retry[i], 0);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      chk("R1", "post-reset snp_valid", sv[i], 0);
      chk("R1", "post-reset bus_retry", retry[i], 0);
    end

    // R2/R3/R4: every bus type, plus a valid idle-type cycle
    step(1, 1, 'h100, 0, 0, 0, 0, 0);
    step(1, 2, 'h104, 0, 0, 0, 0, 0);
    step(1, 3, 'h108, 0, 0, 0, 0, 0);
    step(1, 0, 'h10C, 0, 0, 0, 0, 0);
    step(0, 1, 'h110, 0, 0, 0, 0, 0);
    idle();

    // R5/R6/R7: local fills with both shared levels, non-read requests
    step(0, 0, 0, 0, 0, 1, 1, 'h20);
    step(0, 0, 0, 1, 0, 1, 1, 'h24);
    step(1, 1, 'h28, 1, 0, 1, 2, 'h28);
    step(0, 0, 0, 0, 0, 1, 3, 'h2C);
    step(0, 0, 0, 1, 0, 0, 1, 'h30);

    // R8/R9: hit on Modified, wrong write-backs, then the matching one
    step(1, 1, 'h200, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0, 0, "R8");
    idle("R8");
    step(0, 0, 0, 0, 0, 1, 3, 'h204, "R9");
    step(0, 0, 0, 0, 0, 1, 1, 'h200, "R9");
    step(0, 0, 0, 0, 0, 1, 2, 'h200, "R9");
    idle("R9");
    step(0, 0, 0, 0, 0, 1, 3, 'h200, "R8");
    idle("R8");
    idle("R8");

    // R10: second hit lands in the same cycle as the first write-back
    step(1, 1, 'h300, 0, 0, 0, 0, 0);
    step(1, 2, 'h310, 0, 1, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 1, 1, 3, 'h300, "R10");
    idle("R10");
    step(0, 0, 0, 0, 0, 1, 3, 'h300, "R10");
    idle("R10");
    step(0, 0, 0, 0, 0, 1, 3, 'h310, "R10");
    idle("R10");

    // Random mix over a small address set
    for (int n = 0; n < 600; n++) begin
      step($urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 3) << 8,
           $urandom_range(0, 1), $urandom_range(0, 4) == 0,
           $urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 3) << 8,
           "R8");
    end
    idle();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule